// File: doc/BRIEF.md
# Trigger-Windowed Acquisition Controller

This block decides which pacer ticks become conversion commands for an analog-to-digital converter, according to where each tick falls relative to an external trigger event. The host loads a mode and two sample counts and pulses a start strobe. The controller then either converts freely, captures a window that ends at the trigger, captures a window that begins at the trigger, or captures a window that straddles it. A stop strobe aborts any run. A one-cycle done pulse marks a completed window.

Before the trigger, a circular slot index wraps over the programmed pre-trigger depth, so the host can locate the newest samples in its ring. After the trigger, the slot index counts post-trigger samples from zero. A flag reports whether the pre-trigger ring had filled when the trigger arrived. The trigger pin is asynchronous and is brought into the clock domain by a two-flop synchronizer. Only its first rising edge in a run is used.

States: IDLE (waiting for start), FREE (free-running), PRE (filling the pre-trigger ring while watching for the trigger), ARM (waiting for the trigger, no conversions), POST (counting post-trigger samples). Transitions:
- IDLE to FREE, PRE or ARM on start, chosen by the mode.
- PRE to IDLE on trigger in pre mode.
- PRE to POST on trigger in middle mode.
- PRE to IDLE on trigger in middle mode when the post count is zero.
- ARM to POST on trigger.
- ARM to IDLE on trigger when the post count is zero.
- POST to IDLE on the last sample.
- Any busy state to IDLE on stop.

Top module: `trig_acq_ctrl`

## Requirements
- R1: After reset, busy, done, conv_cmd, pre_short and slot_idx are all 0.
- R2: Mode 0 (free): after start, every pacer tick gives one conv_cmd pulse on the next cycle until stop; the trigger is ignored and done never rises.
- R3: Mode 1 (pre): ticks are converted from start until the trigger is accepted, including a tick in the acceptance cycle; slot_idx counts 0..pre_count-1 and wraps; done pulses for one cycle together with busy falling; with pre_count 0 no tick is converted.
- R4: Mode 2 (post): no tick is converted before the trigger is accepted, nor in the acceptance cycle; then exactly post_count ticks are converted with slot_idx 0..post_count-1, and done rises in the same cycle as the last conv_cmd.
- R5: Mode 2 with post_count 0: done pulses at trigger acceptance and no conv_cmd is issued.
- R6: Mode 3 (middle): pre phase behaves as R3; after the trigger, post_count further ticks are converted with slot_idx counting from 0, then done; with post_count 0, done pulses at acceptance.
- R7: In modes 1 and 3, pre_short is set at trigger acceptance when fewer than pre_count ticks (counting one in the acceptance cycle) were converted since start; otherwise it is cleared; start clears it; it holds between runs.
- R8: ext_trig passes two synchronizer flops; a rise set up before clock edge k is acted on at edge k+2; only the first rise in a run counts, and a held level or later rises have no effect until the next start.
- R9: user_stop while busy returns to idle at the next edge with no done pulse and no conversion for a tick in that cycle.
- R10: Mode and counts are latched at start; start while busy, and input changes during a run, have no effect.
- R11: conv_cmd is a registered pulse that appears only in the cycle after a sampled pacer tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pacer_tick | input | 1 | One-cycle pacer tick |
| ext_trig | input | 1 | Asynchronous external trigger level |
| user_start | input | 1 | Start strobe |
| user_stop | input | 1 | Abort strobe |
| mode | input | 2 | 0 free, 1 pre, 2 post, 3 middle |
| pre_count | input | CW | Pre-trigger depth |
| post_count | input | CW | Post-trigger count (post and middle modes) |
| conv_cmd | output | 1 | Conversion command pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle window-complete pulse |
| pre_short | output | 1 | Pre-trigger ring not filled at trigger |
| slot_idx | output | CW | Slot index of the latest conversion |

## Verification
A pacer tick and the accepted trigger edge can fall in the same cycle. The bench holds the tick high across the synchronizer latency so that a tick lands on the acceptance edge. In pre and middle modes that tick must appear as a conversion with the next ring slot, and it must count toward the pre_short decision. In post mode the same coincidence must yield no conversion, so the first post-trigger slot belongs to the following tick.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_PRE  = 2'd1,
        MODE_POST = 2'd2,
        MODE_MID  = 2'd3
    } acq_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FREE,
        S_PRE,
        S_ARM,
        S_POST
    } acq_state_e;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], trig_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pre_ring.sv
module pre_ring #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] ptr,
    output logic          short_o
);
    logic [CW-1:0] fill_q;
    logic [CW:0]   fill_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            fill_q <= '0;
        end else if (clr) begin
            ptr    <= '0;
            fill_q <= '0;
        end else if (step) begin
            ptr <= (ptr == limit - 1'b1) ? '0 : ptr + 1'b1;
            if (fill_q != limit) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    assign fill_next = {1'b0, fill_q} + {{CW{1'b0}}, step};
    assign short_o   = fill_next < {1'b0, limit};
endmodule

// File: rtl/post_down.sv
module post_down #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    output logic [CW-1:0] rem,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (load) begin
            rem <= load_val;
        end else if (step && rem != '0) begin
            rem <= rem - 1'b1;
        end
    end

    assign last = (rem == {{(CW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/trig_acq_ctrl.sv
module trig_acq_ctrl
    import acq_pkg::*;
#(
    parameter int CW          = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pacer_tick,
    input  logic          ext_trig,
    input  logic          user_start,
    input  logic          user_stop,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] pre_count,
    input  logic [CW-1:0] post_count,
    output logic          conv_cmd,
    output logic          busy,
    output logic          done,
    output logic          pre_short,
    output logic [CW-1:0] slot_idx
);
    acq_state_e    state_q, state_d;
    acq_mode_e     mode_q;
    logic [CW-1:0] n1_q, n2_q;

    logic          trig_rise;
    logic [CW-1:0] ring_ptr, post_rem;
    logic          ring_short, post_last;

    logic          start_take, conv, fin, trig_take;
    logic          ring_step, post_load, post_step;

    trig_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (ext_trig),
        .rise       (trig_rise)
    );

    pre_ring #(.CW(CW)) ring_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_take),
        .step    (ring_step),
        .limit   (n1_q),
        .ptr     (ring_ptr),
        .short_o (ring_short)
    );

    post_down #(.CW(CW)) down_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (post_load),
        .load_val (n2_q),
        .step     (post_step),
        .rem      (post_rem),
        .last     (post_last)
    );

    // Next-state and event decode
    always_comb begin
        state_d    = state_q;
        start_take = 1'b0;
        conv       = 1'b0;
        fin        = 1'b0;
        trig_take  = 1'b0;
        ring_step  = 1'b0;
        post_load  = 1'b0;
        post_step  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (user_start && !user_stop) begin
                    start_take = 1'b1;
                    unique case (acq_mode_e'(mode))
                        MODE_FREE: state_d = S_FREE;
                        MODE_PRE:  state_d = S_PRE;
                        MODE_MID:  state_d = S_PRE;
                        MODE_POST: state_d = S_ARM;
                    endcase
                end
            end
            S_FREE: begin
                if (user_stop) begin
                    state_d = S_IDLE;
                end else begin
                    conv = pacer_tick;
                end
            end
            S_PRE: begin
                if (user_stop) begin
                    state_d = S_IDLE;
                end else begin
                    ring_step = pacer_tick && (n1_q != '0);
                    conv      = ring_step;
                    if (trig_rise) begin
                        trig_take = 1'b1;
                        if (mode_q == MODE_PRE || n2_q == '0) begin
                            fin     = 1'b1;
                            state_d = S_IDLE;
                        end else begin
                            post_load = 1'b1;
                            state_d   = S_POST;
                        end
                    end
                end
            end
            S_ARM: begin
                if (user_stop) begin
                    state_d = S_IDLE;
                end else if (trig_rise) begin
                    if (n2_q == '0) begin
                        fin     = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        post_load = 1'b1;
                        state_d   = S_POST;
                    end
                end
            end
            S_POST: begin
                if (user_stop) begin
                    state_d = S_IDLE;
                end else if (pacer_tick) begin
                    conv      = 1'b1;
                    post_step = 1'b1;
                    if (post_last) begin
                        fin     = 1'b1;
                        state_d = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Run configuration, captured at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FREE;
            n1_q   <= '0;
            n2_q   <= '0;
        end else if (start_take) begin
            mode_q <= acq_mode_e'(mode);
            n1_q   <= pre_count;
            n2_q   <= post_count;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_cmd  <= 1'b0;
            done      <= 1'b0;
            pre_short <= 1'b0;
            slot_idx  <= '0;
        end else begin
            conv_cmd <= conv;
            done     <= fin;
            if (start_take) begin
                pre_short <= 1'b0;
            end else if (trig_take) begin
                pre_short <= ring_short;
            end
            if (conv) begin
                unique case (state_q)
                    S_PRE:   slot_idx <= ring_ptr;
                    S_POST:  slot_idx <= n2_q - post_rem;
                    default: slot_idx <= '0;
                endcase
            end
        end
    end

    assign busy = (state_q != S_IDLE);
endmodule

// File: rtl/trig_acq_chk.sv
module trig_acq_chk (
    input logic clk,
    input logic rst_n,
    input logic pacer_tick,
    input logic user_start,
    input logic user_stop,
    input logic conv_cmd,
    input logic busy,
    input logic done
);
    // R11: a conversion follows a sampled tick during a run
    a_r11_conv_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        conv_cmd |-> ($past(pacer_tick) && $past(busy)));

    // R9: stop aborts without done or conversion
    a_r9_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (user_stop && busy) |=> (!busy && !done && !conv_cmd));

    // R3: done lasts exactly one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done coincides with the return to idle
    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: a run begins only from a start strobe
    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(user_start));
endmodule

bind trig_acq_ctrl trig_acq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pacer_tick (pacer_tick),
    .user_start (user_start),
    .user_stop  (user_stop),
    .conv_cmd   (conv_cmd),
    .busy       (busy),
    .done       (done)
);

// File: tb/trig_acq_ctrl_tb_top.sv
module trig_acq_ctrl_tb_top;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pacer_tick, ext_trig, user_start, user_stop;
    logic [1:0]    mode;
    logic [CW-1:0] pre_count, post_count;
    logic          conv_cmd, busy, done, pre_short;
    logic [CW-1:0] slot_idx;

    int n_run  = 0;
    int n_fail = 0;
    int nconv  = 0;
    int ndone  = 0;
    int slog [0:63];
    bit finished = 0;

    always #10 clk = ~clk;

    trig_acq_ctrl #(.CW(CW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pacer_tick (pacer_tick),
        .ext_trig   (ext_trig),
        .user_start (user_start),
        .user_stop  (user_stop),
        .mode       (mode),
        .pre_count  (pre_count),
        .post_count (post_count),
        .conv_cmd   (conv_cmd),
        .busy       (busy),
        .done       (done),
        .pre_short  (pre_short),
        .slot_idx   (slot_idx)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle with the given tick; outputs of that cycle are logged at the next negedge
    task automatic cyc(input logic t);
        pacer_tick = t;
        @(negedge clk);
        pacer_tick = 1'b0;
        if (conv_cmd) begin
            if (nconv < 64) slog[nconv] = int'(slot_idx);
            nconv++;
        end
        if (done) ndone++;
    endtask

    task automatic clr_log();
        nconv = 0;
        ndone = 0;
    endtask

    task automatic start_run(input logic [1:0] m, input int n1, input int n2);
        mode       = m;
        pre_count  = CW'(n1);
        post_count = CW'(n2);
        user_start = 1'b1;
        cyc(1'b0);
        user_start = 1'b0;
    endtask

    task automatic idle_trig();
        ext_trig = 1'b0;
        for (int i = 0; i < 4; i++) cyc(1'b0);
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "conv_cmd", conv_cmd, 0);
        chk("R1", "pre_short", pre_short, 0);
        chk("R1", "slot_idx", int'(slot_idx), 0);
    endtask

    task automatic t_free();
        clr_log();
        start_run(2'd0, 3, 3);
        chk("R2", "busy after start", busy, 1);
        cyc(1); cyc(0); cyc(1);
        ext_trig = 1'b1;
        cyc(1); cyc(0); cyc(0); cyc(1);
        chk("R2", "conversions", nconv, 4);
        chk("R2", "still busy, trigger ignored", busy, 1);
        user_stop = 1'b1;
        cyc(1);
        user_stop = 1'b0;
        chk("R9", "busy after stop", busy, 0);
        chk("R9", "no conv on stop cycle", nconv, 4);
        chk("R2", "done never", ndone, 0);
        idle_trig();
    endtask

    task automatic t_pre();
        clr_log();
        start_run(2'd1, 3, 0);
        for (int i = 0; i < 5; i++) cyc(1);
        ext_trig = 1'b1;
        cyc(1); cyc(1);
        chk("R8", "not yet taken", busy, 1);
        cyc(1);
        chk("R3", "done at acceptance", done, 1);
        chk("R3", "busy falls", busy, 0);
        chk("R3", "conversions incl. acceptance tick", nconv, 8);
        chk("R3", "slot 3 wrapped", slog[3], 0);
        chk("R3", "last slot", slog[7], 1);
        chk("R7", "ring filled", pre_short, 0);
        cyc(1); cyc(1);
        chk("R3", "no conv after done", nconv, 8);
        chk("R3", "done one cycle", ndone, 1);
        idle_trig();
    endtask

    task automatic t_pre_short();
        clr_log();
        start_run(2'd1, 4, 0);
        cyc(1);
        ext_trig = 1'b1;
        cyc(0); cyc(0); cyc(1);
        chk("R7", "short flag", pre_short, 1);
        chk("R7", "conversions", nconv, 2);
        idle_trig();
        chk("R7", "flag holds", pre_short, 1);
        start_run(2'd1, 0, 0);
        chk("R7", "start clears", pre_short, 0);
        clr_log();
        cyc(1);
        ext_trig = 1'b1;
        cyc(1); cyc(1); cyc(1);
        chk("R3", "pre_count 0 no conv", nconv, 0);
        chk("R3", "pre_count 0 done", ndone, 1);
        idle_trig();
    endtask

    task automatic t_post();
        clr_log();
        start_run(2'd2, 0, 3);
        cyc(1); cyc(1);
        ext_trig = 1'b1;
        cyc(1); cyc(1); cyc(1);
        chk("R4", "no conv before/at trigger", nconv, 0);
        cyc(1); cyc(0); cyc(1);
        chk("R4", "not done early", ndone, 0);
        cyc(1);
        chk("R4", "done with last conv", done, 1);
        chk("R4", "conv same cycle", conv_cmd, 1);
        chk("R4", "conversions", nconv, 3);
        chk("R4", "first slot", slog[0], 0);
        chk("R4", "last slot", slog[2], 2);
        ext_trig = 1'b0;
        cyc(1); ext_trig = 1'b1;
        cyc(1); cyc(1); cyc(1); cyc(1);
        chk("R8", "rise while idle ignored", nconv, 3);
        chk("R8", "stays idle", busy, 0);
        idle_trig();
    endtask

    task automatic t_post_zero();
        clr_log();
        start_run(2'd2, 0, 0);
        ext_trig = 1'b1;
        cyc(1); cyc(1); cyc(1);
        chk("R5", "done", done, 1);
        chk("R5", "no conv", nconv, 0);
        idle_trig();
    endtask

    task automatic t_mid();
        clr_log();
        start_run(2'd3, 2, 2);
        cyc(1); cyc(1); cyc(1);
        ext_trig = 1'b1;
        cyc(0); cyc(0); cyc(1);
        chk("R6", "pre conversions", nconv, 4);
        chk("R6", "acceptance tick slot", slog[3], 1);
        chk("R6", "busy in post", busy, 1);
        chk("R7", "mid not short", pre_short, 0);
        ext_trig = 1'b0;
        cyc(0); cyc(0);
        ext_trig = 1'b1;
        cyc(0); cyc(0); cyc(0);
        chk("R8", "second rise ignored", busy, 1);
        cyc(1);
        cyc(1);
        chk("R6", "done", done, 1);
        chk("R6", "total conversions", nconv, 6);
        chk("R6", "post slot 0", slog[4], 0);
        chk("R6", "post slot 1", slog[5], 1);
        idle_trig();
        clr_log();
        start_run(2'd3, 2, 0);
        ext_trig = 1'b1;
        cyc(0); cyc(0); cyc(0);
        chk("R6", "zero post done", ndone, 1);
        chk("R7", "mid short", pre_short, 1);
        idle_trig();
    endtask

    task automatic t_stop();
        clr_log();
        start_run(2'd2, 0, 5);
        ext_trig = 1'b1;
        cyc(0); cyc(0); cyc(0);
        cyc(1); cyc(1);
        user_stop = 1'b1;
        cyc(1);
        user_stop = 1'b0;
        chk("R9", "busy cleared", busy, 0);
        chk("R9", "no done", ndone, 0);
        chk("R9", "conv count", nconv, 2);
        cyc(1);
        chk("R11", "no conv idle tick", nconv, 2);
        idle_trig();
    endtask

    task automatic t_latch();
        clr_log();
        start_run(2'd1, 2, 5);
        mode       = 2'd2;
        post_count = CW'(7);
        start_run(2'd2, 0, 5);
        ext_trig = 1'b1;
        cyc(1); cyc(1); cyc(1);
        chk("R10", "pre behaviour kept", ndone, 1);
        chk("R10", "conversions", nconv, 3);
        idle_trig();
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pacer_tick = 1'b0; ext_trig = 1'b0;
        user_start = 1'b0; user_stop = 1'b0;
        mode = 2'd0; pre_count = '0; post_count = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_free();
        t_pre();
        t_pre_short();
        t_post();
        t_post_zero();
        t_mid();
        t_stop();
        t_latch();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule